// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block guesses whether a conditional branch will be taken. It holds a table of entries, and the low bits of the branch address pick one entry. Each entry holds 2^m saturating counters of n bits each. An m-bit register records the outcomes of the most recently resolved branches, and its value picks which counter of the entry is used. Two branches at the same address can therefore be predicted differently, depending on what the branches before them did. The storage is 2^m × n × (number of entries) bits.

The fetch side presents a PC and receives a guess in the same cycle, with no register on the path. It also receives the history value that produced the guess, and it carries that value along with the branch. When the branch resolves, the back end presents the PC, the real outcome and that carried history. The block then adjusts the one counter the guess came from and shifts the outcome into the history. A restore input reloads the history after a flush. The next history value comes from a three-way choice, named HOLD, SHIFT and LOAD. HOLD is taken when neither update nor restore is asserted. SHIFT is taken when an update arrives without a restore. LOAD is taken whenever restore is asserted, and it wins over SHIFT. With m=0 every entry has a single counter, so the block acts as a plain n-bit prediction buffer. With n=1 that counter is a single bit, which flips on every misprediction.

Top module: `corr_predictor`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value 2^(n-1)-1 (1 for n=2), and the history is all zeros. Every guess is therefore not-taken and `guess_hist` reads 0.
- R2: In the same cycle, `guess_taken` is the most significant bit of the counter in entry `fetch_pc[PC_LSB +: IDX_BITS]` at slot number equal to the current history. PCs that share those index bits share an entry.
- R3: When `upd_valid` is high, the counter at entry `upd_pc[PC_LSB +: IDX_BITS]`, slot `upd_hist`, goes up by one if `upd_taken` is 1 and down by one if it is 0. It stays at 2^n-1 when it is already there and taken, and it stays at 0 when it is already there and not taken.
- R4: An update changes only that one counter. The other slots of the same entry and all other entries keep their values.
- R5: An update without restore shifts the history left, and `upd_taken` enters at bit 0. The oldest bit is dropped.
- R6: When `restore_valid` is high, the history is loaded with `restore_hist` at the next edge. This takes priority over a shift in the same cycle, and the counter update of that cycle is still applied.
- R7: When a guess and an update hit the same counter in the same cycle, the guess reflects the value before the update.
- R8: `guess_hist` always equals the current history register, which is the value that selects the slot for the guess.
- R9: With neither `upd_valid` nor `restore_valid` high, no counter and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address of the branch being guessed |
| guess_taken | output | 1 | Guess: 1 = taken |
| guess_hist | output | max(HIST_BITS,1) | History value that produced the guess |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_hist | input | max(HIST_BITS,1) | History captured when that branch was guessed |
| restore_valid | input | 1 | Reload the history register |
| restore_hist | input | max(HIST_BITS,1) | Value to reload |

## Verification
A guess and an update can fall in the same cycle on the same counter. The bench provokes this by driving an identical `fetch_pc` and `upd_pc`, and by holding the history equal to `upd_hist` through restores. It then judges the guess against the value the model held before the update. A restore can also coincide with an update. That case is judged by checking that the next `guess_hist` is the restore value while the counter still moved. Random traffic over a few aliasing addresses repeats both overlaps many times.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;
    typedef enum logic [1:0] {
        HOP_HOLD  = 2'd0,
        HOP_SHIFT = 2'd1,
        HOP_LOAD  = 2'd2
    } hist_op_e;
endpackage

// File: rtl/corr_bp_history.sv
module corr_bp_history
    import corr_bp_pkg::*;
#(
    parameter int HIST_BITS = 2,
    localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          shift_bit,
    input  logic          load_en,
    input  logic [HW-1:0] load_val,
    output logic [HW-1:0] hist_q
);
    generate
        if (HIST_BITS == 0) begin : g_nohist
            assign hist_q = '0;
            logic unused_hist_in;
            assign unused_hist_in = ^{clk, rst_n, shift_en, shift_bit, load_en, load_val};
        end else begin : g_hist
            localparam logic [HW-1:0] LOW_MASK = HW'((1 << (HW - 1)) - 1);
            hist_op_e      op;
            logic [HW-1:0] hist_r;
            logic [HW-1:0] hist_d;
            logic [HW:0]   shifted;

            assign shifted = {hist_r, shift_bit};

            always_comb begin
                if (load_en)       op = HOP_LOAD;
                else if (shift_en) op = HOP_SHIFT;
                else               op = HOP_HOLD;
            end

            always_comb begin
                unique case (op)
                    HOP_LOAD:  hist_d = load_val;
                    HOP_SHIFT: hist_d = shifted[HW-1:0];
                    HOP_HOLD:  hist_d = hist_r;
                    default:   hist_d = hist_r;
                endcase
            end

            always_ff @(posedge clk) begin
                if (!rst_n) hist_r <= '0;
                else        hist_r <= hist_d;
            end

            assign hist_q = hist_r;

            // R5: new outcome enters at bit 0
            a_r5_new_bit: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_en && !load_en) |=> (hist_r[0] == $past(shift_bit)));
            // R5: older bits move up one place
            a_r5_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_en && !load_en) |=> ((hist_r >> 1) == ($past(hist_r) & LOW_MASK)));
            // R6: restore wins
            a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
                load_en |=> (hist_r == $past(load_val)));
            // R9: quiet cycles keep history
            a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!shift_en && !load_en) |=> $stable(hist_r));
        end
    endgenerate
endmodule

// File: rtl/corr_bp_ctr_step.sv
module corr_bp_ctr_step #(
    parameter int CTR_BITS = 2
) (
    input  logic [CTR_BITS-1:0] cur,
    input  logic                taken,
    output logic [CTR_BITS-1:0] nxt
);
    localparam logic [CTR_BITS-1:0] CTR_MAX = {CTR_BITS{1'b1}};
    localparam logic [CTR_BITS-1:0] CTR_ONE = CTR_BITS'(1);

    always_comb begin
        if (taken) nxt = (cur == CTR_MAX) ? cur : cur + CTR_ONE;
        else       nxt = (cur == '0)      ? cur : cur - CTR_ONE;
    end
endmodule

// File: rtl/corr_bp_table.sv
module corr_bp_table #(
    parameter int IDX_BITS  = 6,
    parameter int HIST_BITS = 2,
    parameter int CTR_BITS  = 2,
    localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx,
    input  logic [HW-1:0]       rd_slot,
    output logic [CTR_BITS-1:0] rd_ctr,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic [HW-1:0]       wr_slot,
    input  logic                wr_taken
);
    localparam int ENTRIES = 1 << IDX_BITS;
    localparam int SLOTS   = 1 << HIST_BITS;
    localparam int ROW_W   = SLOTS * CTR_BITS;
    localparam logic [CTR_BITS-1:0] WEAK_NT = CTR_BITS'((1 << (CTR_BITS - 1)) - 1);
    localparam logic [CTR_BITS-1:0] CTR_MAX = {CTR_BITS{1'b1}};
    localparam logic [ROW_W-1:0]    RESET_ROW = {SLOTS{WEAK_NT}};

    logic [ROW_W-1:0]    row_q [ENTRIES];
    logic [ROW_W-1:0]    rd_row;
    logic [ROW_W-1:0]    wr_row_old;
    logic [ROW_W-1:0]    wr_row_new;
    logic [CTR_BITS-1:0] wr_old;
    logic [CTR_BITS-1:0] wr_new;

    assign rd_row     = row_q[rd_idx];
    assign wr_row_old = row_q[wr_idx];

    always_comb begin
        rd_ctr = rd_row[CTR_BITS-1:0];
        wr_old = wr_row_old[CTR_BITS-1:0];
        for (int s = 0; s < SLOTS; s++) begin
            if (s == int'(rd_slot)) rd_ctr = rd_row[s*CTR_BITS +: CTR_BITS];
            if (s == int'(wr_slot)) wr_old = wr_row_old[s*CTR_BITS +: CTR_BITS];
        end
    end

    corr_bp_ctr_step #(.CTR_BITS(CTR_BITS)) i_step (
        .cur   (wr_old),
        .taken (wr_taken),
        .nxt   (wr_new)
    );

    // whole row rewritten as one unit
    always_comb begin
        wr_row_new = wr_row_old;
        for (int s = 0; s < SLOTS; s++) begin
            if (s == int'(wr_slot)) wr_row_new[s*CTR_BITS +: CTR_BITS] = wr_new;
        end
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n)
                row_q[e] <= RESET_ROW;
            else if (wr_en && (wr_idx == IDX_BITS'(e)))
                row_q[e] <= wr_row_new;
        end
    end

    // R3: saturation at the top
    a_r3_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_old == CTR_MAX) |-> (wr_new == CTR_MAX));
    // R3: saturation at the bottom
    a_r3_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_old == '0) |-> (wr_new == '0));

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
            // R4 and R9: untouched entries keep their contents
            a_r4_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_idx == IDX_BITS'(e)) |=> $stable(row_q[e]));
        end
    endgenerate
endmodule

// File: rtl/corr_predictor.sv
module corr_predictor #(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int IDX_BITS  = 6,
    parameter int HIST_BITS = 2,
    parameter int CTR_BITS  = 2,
    localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            guess_taken,
    output logic [HW-1:0]   guess_hist,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [HW-1:0]   upd_hist,
    input  logic            restore_valid,
    input  logic [HW-1:0]   restore_hist
);
    logic [HW-1:0]       hist_q;
    logic [IDX_BITS-1:0] fetch_idx;
    logic [IDX_BITS-1:0] upd_idx;
    logic [CTR_BITS-1:0] sel_ctr;
    logic                unused_pc_bits;

    assign fetch_idx      = fetch_pc[PC_LSB +: IDX_BITS];
    assign upd_idx        = upd_pc[PC_LSB +: IDX_BITS];
    assign unused_pc_bits = ^{fetch_pc, upd_pc};

    corr_bp_history #(.HIST_BITS(HIST_BITS)) i_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .load_en   (restore_valid),
        .load_val  (restore_hist),
        .hist_q    (hist_q)
    );

    corr_bp_table #(
        .IDX_BITS  (IDX_BITS),
        .HIST_BITS (HIST_BITS),
        .CTR_BITS  (CTR_BITS)
    ) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_idx),
        .rd_slot  (hist_q),
        .rd_ctr   (sel_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_slot  (upd_hist),
        .wr_taken (upd_taken)
    );

    assign guess_taken = sel_ctr[CTR_BITS-1];
    assign guess_hist  = hist_q;

    // R8: exported history moves only on update or restore
    a_r8_hist_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && !restore_valid) |=> $stable(guess_hist));
endmodule

// File: tb/test_corr_predictor.sv
`timescale 1ns/1ps
module test_corr_predictor;
    localparam int IDXB = 6;
    localparam int ENT  = 1 << IDXB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        guess_taken;
    logic [1:0]  guess_hist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [1:0]  upd_hist = '0;
    logic        restore_valid = 1'b0;
    logic [1:0]  restore_hist = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int ctr_m [ENT][4];
    logic [1:0] hist_m = '0;

    always #2.5 clk = ~clk;

    corr_predictor i_corr_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .guess_taken(guess_taken), .guess_hist(guess_hist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_hist(upd_hist), .restore_valid(restore_valid),
        .restore_hist(restore_hist)
    );

    function automatic int idx_of(input logic [31:0] pc);
        return int'((pc >> 2) & 32'(ENT - 1));
    endfunction

    function automatic int guess_of(input logic [31:0] pc);
        return (ctr_m[idx_of(pc)][hist_m] >= 2) ? 1 : 0;
    endfunction

    task automatic chk(input int got, input int exp, input string tag);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(input logic [31:0] ppc, input logic uv,
                        input logic [31:0] upc, input logic ut,
                        input logic [1:0] uh, input logic rv,
                        input logic [1:0] rh, input string tag);
        int c;
        @(negedge clk);
        fetch_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        upd_hist = uh; restore_valid = rv; restore_hist = rh;
        #1;
        chk(int'(guess_taken), guess_of(ppc), tag);
        chk(int'(guess_hist), int'(hist_m), {tag, " R8"});
        @(posedge clk);
        if (uv) begin
            c = ctr_m[idx_of(upc)][uh];
            if (ut && c < 3) c++;
            else if (!ut && c > 0) c--;
            ctr_m[idx_of(upc)][uh] = c;
        end
        if (rv)      hist_m = rh;
        else if (uv) hist_m = {hist_m[0], ut};
    endtask

    task automatic idle(input logic [31:0] ppc, input string tag);
        step(ppc, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 2'd0, tag);
    endtask

    task automatic sethist(input logic [1:0] h);
        step(32'h0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b1, h, "R6 set history");
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished (R1..R9 unfinished)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int e = 0; e < ENT; e++)
            for (int s = 0; s < 4; s++) ctr_m[e][s] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle(32'h0000_0000, "R1 reset guess pc0");
        idle(32'h0000_00FC, "R1 reset guess pc_fc");
        idle(32'h0000_1234, "R1 reset guess pc_1234");

        // R3 and R7: count up on slot 1 of pc 0x40, guessing same counter
        for (int k = 0; k < 4; k++)
            step(32'h40, 1'b1, 32'h40, 1'b1, 2'd1, 1'b1, 2'd1, "R3 R7 count up");
        idle(32'h40, "R3 saturated high");
        step(32'h40, 1'b1, 32'h40, 1'b0, 2'd1, 1'b1, 2'd1, "R3 one down");
        idle(32'h40, "R3 still taken after one down");
        // R2: aliasing pc shares the entry
        idle(32'h140, "R2 alias shares entry");
        // R4: other slots of same entry untouched
        sethist(2'd0); idle(32'h40, "R4 slot0 untouched");
        sethist(2'd2); idle(32'h40, "R4 slot2 untouched");
        sethist(2'd3); idle(32'h40, "R4 slot3 untouched");
        idle(32'h44, "R4 neighbour entry untouched");

        // R3: saturation low on pc 0x80 slot 2
        for (int k = 0; k < 3; k++)
            step(32'h80, 1'b1, 32'h80, 1'b0, 2'd2, 1'b1, 2'd2, "R3 count down");
        step(32'h80, 1'b1, 32'h80, 1'b1, 2'd2, 1'b1, 2'd2, "R3 up from zero");
        step(32'h80, 1'b1, 32'h80, 1'b1, 2'd2, 1'b1, 2'd2, "R3 up again");
        idle(32'h80, "R3 reached taken");

        // R5: shifting history
        sethist(2'd0);
        step(32'h0, 1'b1, 32'h200, 1'b1, 2'd0, 1'b0, 2'd0, "R5 shift 1");
        step(32'h0, 1'b1, 32'h200, 1'b0, 2'd1, 1'b0, 2'd0, "R5 shift 0");
        step(32'h0, 1'b1, 32'h200, 1'b1, 2'd2, 1'b0, 2'd0, "R5 shift 1 again");
        idle(32'h200, "R5 history after shifts");

        // R6: restore and update together
        step(32'h300, 1'b1, 32'h300, 1'b1, 2'd3, 1'b1, 2'd3, "R6 restore with update");
        idle(32'h300, "R6 counter moved, history restored");

        // R9: quiet cycles
        for (int k = 0; k < 4; k++) idle(32'h40 + 32'(k * 4), "R9 idle no change");

        // random traffic over a small aliasing address set
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] ppc, upc;
            ppc = 32'($urandom_range(0, 11)) << 4;
            upc = 32'($urandom_range(0, 11)) << 4;
            if ($urandom_range(0, 3) == 0) upc = ppc;
            step(ppc, 1'($urandom_range(0, 1)), upc, 1'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
                 2'($urandom_range(0, 3)), "R2 R3 R5 R7 random");
        end

        @(negedge clk);
        upd_valid = 1'b0; restore_valid = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule